// File: doc/BRIEF.md
# Serial Double-Buffered Frequency Word Loader

This block accepts a 16-bit tuning word over a three-wire serial link: a data line, a shift clock and an enable. While the enable is high, each falling edge of the shift clock pushes one data bit into a shift register. The first bit sent is the least significant one. When the enable falls, the collected word is copied into a holding register. That holding register drives a phase accumulator downstream, so the word it presents changes only at a load and never while bits are still arriving.

The three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are found by comparing successive synchronized samples. The block reacts only to edges, never to levels. Each load raises a one-cycle strobe. A sticky valid flag tells the consumer that the holding register has been written at least once since reset.

Top module: `fwl_loader`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `tune_word_o` is 0, `word_strobe_o` is 0 and `word_valid_o` is 0.
- R2: Each falling edge of `ser_clk_i` seen while `ser_en_i` is high captures `ser_dat_i` into bit 15 of the shift register, and the older contents move one place toward bit 0. After 16 such edges, the first bit sent sits at bit 0 and the last bit sent sits at bit 15.
- R3: A falling edge of `ser_en_i` copies the whole shift register into `tune_word_o`.
- R4: `word_strobe_o` is high for exactly one cycle per load, in the cycle in which the new value first appears on `tune_word_o`. `tune_word_o` never changes in a cycle where the strobe is low.
- R5: `word_valid_o` stays low until the first load, then stays high until reset.
- R6: Falling edges of `ser_clk_i` while `ser_en_i` is low leave the shift register unchanged. A later enable pulse with no shift-clock edges reloads the earlier contents.
- R7: Only edges act. A rising edge of the shift clock captures nothing. Holding the shift clock low or high for many cycles produces at most one shift. Holding the enable low produces exactly one load.
- R8: A burst of fewer than 16 bits keeps the older register bits, moved down by the burst length. A burst of more than 16 bits keeps only the last 16.
- R9: `tune_word_o` keeps its previous value while a new word is being shifted in.
- R10: An enable fall driven between two system-clock edges shows up as strobe and new word after the third following rising edge of `clk`, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, LSB first |
| ser_en_i | input | 1 | Serial enable; a falling edge loads the word |
| tune_word_o | output | 16 | Holding register driving the accumulator |
| word_strobe_o | output | 1 | One-cycle pulse marking a new loaded word |
| word_valid_o | output | 1 | High once any word has been loaded |

## Verification
A corrupted shift register cannot be seen while it is being filled. It becomes visible on `tune_word_o` only at the next enable fall, three system cycles after that fall. The bench therefore pairs every kind of disturbance (ignored edges, held levels, short and long bursts) with a load that exposes the register contents. A fault in the edge detectors shows up as a missing, doubled or mistimed strobe. The bench catches it in the exact cycle, because it checks the strobe on either side of its expected position.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    localparam int WORD_W_DEF = 16;
    localparam int SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic sclk_fall;
        logic en_fall;
        logic en_lvl;
        logic en_dly;
        logic dat;
    } ser_evt_t;

    function automatic logic [WORD_W_DEF-1:0] shift_in_msb(
        input logic [WORD_W_DEF-1:0] cur,
        input logic                  bit_in
    );
        return {bit_in, cur[WORD_W_DEF-1:1]};
    endfunction

endpackage

// File: rtl/fwl_sync.sv
module fwl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fwl_edge.sv
module fwl_edge
    import fwl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     en_s,
    input  logic     dat_s,
    output ser_evt_t evt
);
    logic sclk_d;
    logic en_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            en_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            en_d   <= en_s;
        end
    end

    always_comb begin
        evt.sclk_fall = sclk_d & ~sclk_s;
        evt.en_fall   = en_d & ~en_s;
        evt.en_lvl    = en_s;
        evt.en_dly    = en_d;
        evt.dat       = dat_s;
    end
endmodule

// File: rtl/fwl_shift.sv
module fwl_shift
    import fwl_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  ser_evt_t     evt,
    output logic [W-1:0] shreg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (evt.sclk_fall && evt.en_lvl) begin
            shreg <= {evt.dat, shreg[W-1:1]};
        end
    end
endmodule

// File: rtl/fwl_hold.sv
module fwl_hold
    import fwl_pkg::*;
#(
    parameter int W = WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  ser_evt_t     evt,
    input  logic [W-1:0] shreg,
    output logic [W-1:0] word,
    output logic         strobe,
    output logic         valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word   <= '0;
            strobe <= 1'b0;
            valid  <= 1'b0;
        end else begin
            strobe <= evt.en_fall;
            if (evt.en_fall) begin
                word  <= shreg;
                valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fwl_loader.sv
module fwl_loader
    import fwl_pkg::*;
#(
    parameter int WORD_W      = WORD_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_en_i,
    output logic [WORD_W-1:0] tune_word_o,
    output logic              word_strobe_o,
    output logic              word_valid_o
);
    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] syn_in;
    ser_evt_t          evt;
    logic [WORD_W-1:0] shreg;
    logic              en_lvl;
    logic              en_dly;

    assign raw_in = {ser_en_i, ser_clk_i, ser_dat_i};

    fwl_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    fwl_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (syn_in[1]),
        .en_s   (syn_in[2]),
        .dat_s  (syn_in[0]),
        .evt    (evt)
    );

    assign en_lvl = evt.en_lvl;
    assign en_dly = evt.en_dly;

    fwl_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .shreg (shreg)
    );

    fwl_hold #(.W(WORD_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .shreg  (shreg),
        .word   (tune_word_o),
        .strobe (word_strobe_o),
        .valid  (word_valid_o)
    );
endmodule

// File: rtl/fwl_loader_chk.sv
module fwl_loader_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] word,
    input logic         strobe,
    input logic         valid,
    input logic         en_lvl,
    input logic         en_dly,
    input logic [W-1:0] shreg
);
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    p_word_only_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> $stable(word));

    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    p_strobe_sets_valid_r5: assert property (@(posedge clk) disable iff (rst)
        strobe |-> valid);

    p_load_on_en_fall_r3: assert property (@(posedge clk) disable iff (rst)
        strobe |-> ($past(en_dly) && !$past(en_lvl)));

    p_no_shift_when_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(en_lvl) |-> $stable(shreg));
endmodule

bind fwl_loader fwl_loader_chk #(.W(WORD_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .word   (tune_word_o),
    .strobe (word_strobe_o),
    .valid  (word_valid_o),
    .en_lvl (en_lvl),
    .en_dly (en_dly),
    .shreg  (shreg)
);

// File: tb/test_fwl_loader.sv
module test_fwl_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en = 1'b0;
    logic [15:0] tune_word;
    logic        strobe;
    logic        valid;

    int checks = 0;
    int fails = 0;
    int strobe_cnt = 0;
    logic [15:0] model = 16'h0000;
    logic [15:0] exp_q[$];
    bit done = 0;

    always #4 clk = ~clk;

    fwl_loader i_fwl_loader (
        .clk           (clk),
        .rst           (rst),
        .ser_clk_i     (ser_clk),
        .ser_dat_i     (ser_dat),
        .ser_en_i      (ser_en),
        .tune_word_o   (tune_word),
        .word_strobe_o (strobe),
        .word_valid_o  (valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift n bits of b (LSB first) with enable high; bench model per R2
    task automatic shift_bits(input logic [31:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = b[i];
            wait_cyc(3);
            ser_clk = 1'b1;
            wait_cyc(3);
            ser_clk = 1'b0;
            model = {b[i], model[15:1]};
            wait_cyc(3);
        end
    endtask

    // drop enable, push expectation, check latency per R10
    task automatic drop_enable();
        logic [15:0] prev;
        prev = tune_word;
        ser_en = 1'b0;
        exp_q.push_back(model);
        @(negedge clk);
        chk(strobe == 1'b0, "R10 early strobe c1", {31'b0, strobe}, 32'h0);
        @(negedge clk);
        chk(strobe == 1'b0 && tune_word == prev, "R10 early change c2", {15'b0, strobe, tune_word}, {16'b0, prev});
        @(negedge clk);
        chk(strobe == 1'b1, "R10 strobe at third edge", {31'b0, strobe}, 32'h1);
        chk(tune_word == model, "R3 loaded word", {16'b0, tune_word}, {16'b0, model});
        @(negedge clk);
        chk(strobe == 1'b0, "R4 strobe one cycle", {31'b0, strobe}, 32'h0);
        wait_cyc(3);
    endtask

    task automatic send_word(input logic [31:0] b, input int n);
        ser_en = 1'b1;
        wait_cyc(4);
        shift_bits(b, n);
        drop_enable();
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && strobe) begin
                strobe_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected strobe", {16'b0, tune_word}, 32'h0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(tune_word == e, "R3 scoreboard word", {16'b0, tune_word}, {16'b0, e});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt0;
        wait_cyc(5);
        chk(tune_word == 16'h0 && strobe == 1'b0 && valid == 1'b0, "R1 in reset",
            {14'b0, strobe, valid, tune_word}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(tune_word == 16'h0 && strobe == 1'b0 && valid == 1'b0, "R1 after release",
            {14'b0, strobe, valid, tune_word}, 32'h0);
        chk(valid == 1'b0, "R5 valid low before load", {31'b0, valid}, 32'h0);

        // R2 / R3 main patterns
        send_word(32'h0000A5C3, 16);
        chk(tune_word == 16'hA5C3, "R2 LSB-first assembly", {16'b0, tune_word}, 32'hA5C3);
        chk(valid == 1'b1, "R5 valid after load", {31'b0, valid}, 32'h1);
        send_word(32'h00000001, 16);
        chk(tune_word == 16'h0001, "R2 single low bit", {16'b0, tune_word}, 32'h0001);
        send_word(32'h00008000, 16);
        chk(tune_word == 16'h8000, "R2 single high bit", {16'b0, tune_word}, 32'h8000);

        // R9 hold while shifting
        ser_en = 1'b1;
        wait_cyc(4);
        shift_bits(32'h0000FFFF, 8);
        chk(tune_word == 16'h8000 && strobe == 1'b0, "R9 held during shift",
            {16'b0, tune_word}, 32'h8000);
        shift_bits(32'h000000FF, 8);
        drop_enable();
        chk(tune_word == 16'hFFFF, "R2 all ones", {16'b0, tune_word}, 32'hFFFF);

        // R8 partial burst of 4 bits: expect {4'hB, 12'hFFF}
        send_word(32'h0000000B, 4);
        chk(tune_word == 16'hBFFF, "R8 short burst", {16'b0, tune_word}, 32'hBFFF);

        // R8 long burst of 20 bits: last 16 kept
        send_word(32'h0001234F, 20);
        chk(tune_word == 16'h1234, "R8 long burst", {16'b0, tune_word}, 32'h1234);

        // R6 ignored clocks while enable low
        for (int i = 0; i < 8; i++) begin
            ser_dat = 1'b1;
            wait_cyc(3);
            ser_clk = 1'b1;
            wait_cyc(3);
            ser_clk = 1'b0;
            wait_cyc(3);
        end
        chk(strobe_cnt > 0 && tune_word == 16'h1234, "R6 no load from ignored clocks",
            {16'b0, tune_word}, 32'h1234);
        send_word(32'h0, 0);
        chk(tune_word == 16'h1234, "R6 register untouched", {16'b0, tune_word}, 32'h1234);

        // R7 levels held long: one shift only, one load only
        cnt0 = strobe_cnt;
        ser_en = 1'b1;
        wait_cyc(4);
        ser_dat = 1'b1;
        wait_cyc(3);
        ser_clk = 1'b1;
        wait_cyc(40);
        ser_clk = 1'b0;
        wait_cyc(40);
        model = {1'b1, model[15:1]};
        drop_enable();
        chk(tune_word == 16'h891A, "R7 single shift for held levels", {16'b0, tune_word}, 32'h891A);
        wait_cyc(40);
        chk(strobe_cnt == cnt0 + 1, "R7 one load for held enable", strobe_cnt, cnt0 + 1);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule